// File: doc/BRIEF.md
# Eight-Lane FP32 Accumulate and Compare Stage

This block is the back end of a vector floating-point unit. Each cycle it may take eight single-precision product lanes from an upstream multiplier. It adjusts the sign of each lane, and then, lane by lane, either adds the result into a held eight-lane accumulator or keeps the smaller or larger of the accumulator and the product. Lanes never combine with each other. Per-lane flags report which operand a compare kept.

The sign of each lane follows from three controls. An optional absolute-value step comes first. A two-bit add mode then gives a default sign per lane, and an eight-bit mask flips that default for the lanes whose bit is set. A clear request starts from a zero accumulator instead of the held one.

The accumulate path takes two cycles, so an operation that reads the held accumulator can start at most every other cycle. A request that arrives too early is dropped and flagged.

Top module: `fp32_lane_accum`

## Requirements
- R1: The eight lanes are independent; lane i of the accumulator depends only on lane i of the product, lane i of the mask and the shared controls (lane i occupies bits 32i+31..32i of each vector).
- R2: add_mode 0 adds every lane, 1 subtracts every lane, 2 adds even lanes and subtracts odd lanes, 3 subtracts even lanes and adds odd lanes.
- R3: A set bit i of neg_mask inverts lane i's add/subtract choice from R2.
- R4: With abs_en set, the product's sign bit is cleared before the R2/R3 sign choice; sign changes touch only bit 31 of a lane.
- R5: cmp_mode 1 (minimum) keeps the accumulator when it is strictly less than the signed product, otherwise the product; cmp_mode 0 or 3 gives the sum and clears every pick flag.
- R6: cmp_mode 2 (maximum) keeps the accumulator when it is greater than or equal to the signed product, otherwise the product; pick flag i is 1 exactly when lane i kept the accumulator.
- R7: In a compare, +0 and -0 are equal.
- R8: An accepted operation updates acc_o and pick_acc_o, and raises res_valid_o for one cycle, at the second rising edge after the one that accepted it; acc_o holds at all other edges.
- R9: A request without op_clear while an accepted operation is still in its first stage is dropped, and hazard_o is high for the following cycle; a request with op_clear is always accepted.
- R10: With op_clear set, the accumulator operand is +0 for every lane.
- R11: Sums are truncated toward zero.
- R12: Denormal inputs are read as zero of the same sign; an exact zero sum is +0; a nonzero sum below the smallest normal becomes zero with the sign of the larger-magnitude operand.
- R13: A sum beyond the largest finite value becomes infinity; a NaN input is read as infinity of its sign; infinity minus infinity gives +0.
- R14: After reset, acc_o and pick_acc_o are zero and res_valid_o and hazard_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid_i | input | 1 | Request an operation this cycle |
| op_clear_i | input | 1 | Use +0 as accumulator operand |
| add_mode_i | input | 2 | Default lane sign pattern |
| neg_mask_i | input | 8 | Per-lane sign inversion |
| abs_en_i | input | 1 | Clear product sign first |
| cmp_mode_i | input | 2 | 0/3 sum, 1 minimum, 2 maximum |
| prod_i | input | 256 | Eight FP32 product lanes |
| acc_o | output | 256 | Eight FP32 accumulator lanes |
| pick_acc_o | output | 8 | Per-lane compare kept accumulator |
| res_valid_o | output | 1 | Result written this cycle |
| hazard_o | output | 1 | Previous request was dropped |

## Verification
A wrong first-stage valid bit shows within one cycle as a spurious or missing hazard_o pulse, and two cycles after a request as a res_valid_o pulse in the wrong place. A corrupted accumulator lane shows at acc_o on the next result and then carries into every later sum of that lane, so a chained table of operations exposes it at the following compare. A wrong sign decision or a swapped compare shows in the same result as a lane value of the wrong sign or a wrong pick flag.

// File: rtl/fp32_acc_pkg.sv
// Shared types and helpers for the eight-lane FP32 accumulate stage.
// Assumes IEEE single-precision layout: sign bit 31, exponent 30..23.
package fp32_acc_pkg;

    localparam int FP_W  = 32;
    localparam int EXP_W = 8;
    localparam int MAN_W = 23;

    typedef enum logic [1:0] {
        ADD_ALL      = 2'd0,
        SUB_ALL      = 2'd1,
        ADD_SUB_PAIR = 2'd2,
        SUB_ADD_PAIR = 2'd3
    } add_mode_e;

    typedef enum logic [1:0] {
        PICK_SUM     = 2'd0,
        PICK_MIN     = 2'd1,
        PICK_MAX     = 2'd2,
        PICK_SUM_ALT = 2'd3
    } cmp_mode_e;

    // Flush denormals to signed zero and turn NaN into signed infinity.
    function automatic logic [FP_W-1:0] fp_clean(input logic [FP_W-1:0] x);
        logic [EXP_W-1:0] e;
        e = x[FP_W-2 -: EXP_W];
        if (e == '0)
            return {x[FP_W-1], {(FP_W-1){1'b0}}};
        if (e == '1)
            return {x[FP_W-1], {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        return x;
    endfunction

    // Signed integer key whose order matches the float order; both zeros map to 0.
    function automatic logic signed [FP_W:0] fp_order_key(input logic [FP_W-1:0] x);
        logic signed [FP_W:0] mag;
        mag = {2'b00, x[FP_W-2:0]};
        if (x[FP_W-1])
            return -mag;
        return mag;
    endfunction

endpackage

// File: rtl/fp32_lane_prep.sv
// Prepares one product lane: cleans the value, applies the optional absolute
// value, then the add-mode / mask sign choice. Only the sign bit is changed.
// Assumes LANE_IDX parity decides the pair patterns (even lane = first of pair).
module fp32_lane_prep
    import fp32_acc_pkg::*;
#(
    parameter int LANE_IDX = 0
) (
    input  logic [FP_W-1:0] raw_i,
    input  logic [1:0]      add_mode_i,
    input  logic            mask_bit_i,
    input  logic            abs_en_i,
    output logic [FP_W-1:0] opnd_o
);
    localparam bit IS_ODD = (LANE_IDX % 2) == 1;

    logic [FP_W-1:0] clean;
    logic            base_neg;
    logic            mag_sign;

    // Default negate decision for this lane from the add mode.
    always_comb begin
        unique case (add_mode_e'(add_mode_i))
            ADD_ALL:      base_neg = 1'b0;
            SUB_ALL:      base_neg = 1'b1;
            ADD_SUB_PAIR: base_neg = IS_ODD;
            default:      base_neg = !IS_ODD;
        endcase
    end

    // Clean the value, drop its sign for abs, then apply the final sign.
    always_comb begin
        clean    = fp_clean(raw_i);
        mag_sign = abs_en_i ? 1'b0 : clean[FP_W-1];
        opnd_o   = {mag_sign ^ base_neg ^ mask_bit_i, clean[FP_W-2:0]};
    end

endmodule

// File: rtl/fp32_trunc_add.sv
// Combinational FP32 adder with truncation toward zero. Assumes cleaned
// inputs (no denormal, no NaN). Exact zero gives +0, underflow gives signed
// zero, overflow gives infinity, inf + -inf gives +0.
module fp32_trunc_add
    import fp32_acc_pkg::*;
#(
    parameter int GUARD = 26
) (
    input  logic [FP_W-1:0] a_i,
    input  logic [FP_W-1:0] b_i,
    output logic [FP_W-1:0] sum_o
);
    localparam int SIG_W = MAN_W + 1;
    localparam int WX    = SIG_W + GUARD;
    localparam int BIAS_POS = WX - 1;

    function automatic logic [FP_W-1:0] add_trunc(input logic [FP_W-1:0] a,
                                                  input logic [FP_W-1:0] b);
        logic [FP_W-1:0]  lg, sm;
        logic [EXP_W-1:0] el, es, d;
        logic [SIG_W-1:0] ml, ms;
        logic [WX-1:0]    big, sfull, shf;
        logic [WX:0]      tot, nrm;
        logic             stk;
        int               p;
        int               er;
        if (a[30:23] == '1 && b[30:23] == '1)
            return (a[31] != b[31]) ? '0 : a;
        if (a[30:23] == '1)
            return a;
        if (b[30:23] == '1)
            return b;
        if (a[30:0] >= b[30:0]) begin
            lg = a; sm = b;
        end else begin
            lg = b; sm = a;
        end
        el  = lg[30:23];
        es  = sm[30:23];
        ml  = (el == '0) ? '0 : {1'b1, lg[MAN_W-1:0]};
        ms  = (es == '0) ? '0 : {1'b1, sm[MAN_W-1:0]};
        d   = el - es;
        big   = {ml, {GUARD{1'b0}}};
        sfull = {ms, {GUARD{1'b0}}};
        shf   = sfull >> d;
        stk   = ((shf << d) != sfull);
        shf[0] = shf[0] | stk;
        if (lg[31] == sm[31])
            tot = {1'b0, big} + {1'b0, shf};
        else
            tot = {1'b0, big} - {1'b0, shf};
        if (tot == '0)
            return '0;
        p = 0;
        for (int i = 0; i <= WX; i++)
            if (tot[i]) p = i;
        er = int'(el) + p - BIAS_POS;
        if (er >= 255)
            return {lg[31], {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        if (er <= 0)
            return {lg[31], {(FP_W-1){1'b0}}};
        nrm = tot << (WX - p);
        return {lg[31], er[EXP_W-1:0], nrm[WX-1 -: MAN_W]};
    endfunction

    // Whole adder evaluated as one combinational function.
    always_comb sum_o = add_trunc(a_i, b_i);

    // Output guard: no NaN and no denormal ever leave the adder.
    always_comb begin
        if (!$isunknown(sum_o)) begin
            // R13
            no_nan_out_chk: assert (!(sum_o[30:23] == '1 && sum_o[22:0] != '0));
            // R12
            no_denorm_out_chk: assert (!(sum_o[30:23] == '0 && sum_o[22:0] != '0));
        end
    end

endmodule

// File: rtl/fp32_lane_pick.sv
// Second-stage lane logic: sum, minimum or maximum of the accumulator operand
// and the signed product, plus a flag telling whether the accumulator was kept.
// Assumes both operands are already cleaned.
module fp32_lane_pick
    import fp32_acc_pkg::*;
(
    input  logic [FP_W-1:0] acc_op_i,
    input  logic [FP_W-1:0] opnd_i,
    input  logic [1:0]      cmp_mode_i,
    output logic [FP_W-1:0] res_o,
    output logic            pick_acc_o
);
    logic [FP_W-1:0]      sum;
    logic signed [FP_W:0] key_acc, key_op;

    fp32_trunc_add u_add (
        .a_i   (acc_op_i),
        .b_i   (opnd_i),
        .sum_o (sum)
    );

    // Choose between sum and compare winner according to the compare mode.
    always_comb begin
        key_acc = fp_order_key(acc_op_i);
        key_op  = fp_order_key(opnd_i);
        unique case (cmp_mode_e'(cmp_mode_i))
            PICK_MIN: pick_acc_o = (key_acc < key_op);
            PICK_MAX: pick_acc_o = (key_acc >= key_op);
            default:  pick_acc_o = 1'b0;
        endcase
        if (cmp_mode_i == PICK_MIN || cmp_mode_i == PICK_MAX)
            res_o = pick_acc_o ? acc_op_i : opnd_i;
        else
            res_o = sum;
    end

endmodule

// File: rtl/fp32_lane_accum.sv
// Eight-lane FP32 accumulate / compare stage with two-cycle latency.
// Stage 1 registers the signed product lanes and the accumulator operand;
// stage 2 writes the new accumulator and pick flags. A request that reads the
// accumulator while stage 1 is occupied is dropped and flagged.
// Assumes LANES is even (pair add modes).
module fp32_lane_accum
    import fp32_acc_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  op_valid_i,
    input  logic                  op_clear_i,
    input  logic [1:0]            add_mode_i,
    input  logic [LANES-1:0]      neg_mask_i,
    input  logic                  abs_en_i,
    input  logic [1:0]            cmp_mode_i,
    input  logic [LANES*32-1:0]   prod_i,
    output logic [LANES*32-1:0]   acc_o,
    output logic [LANES-1:0]      pick_acc_o,
    output logic                  res_valid_o,
    output logic                  hazard_o
);
    localparam int VEC_W = LANES * FP_W;

    logic             accept;
    logic             s1_vld;
    cmp_mode_e        s1_cmp;
    logic [VEC_W-1:0] s1_accop;
    logic [VEC_W-1:0] s1_opnd;
    logic [VEC_W-1:0] prep_vec;
    logic [VEC_W-1:0] res_vec;
    logic [LANES-1:0] pick_vec;
    logic [VEC_W-1:0] acc_q;
    logic [LANES-1:0] pick_q;
    logic             res_vld_q;
    logic             hazard_q;

    // Accept unless the request needs the accumulator and stage 1 is busy.
    always_comb accept = op_valid_i && (!s1_vld || op_clear_i);

    genvar l;
    generate
        for (l = 0; l < LANES; l++) begin : g_lane
            fp32_lane_prep #(.LANE_IDX(l)) u_prep (
                .raw_i      (prod_i[l*FP_W +: FP_W]),
                .add_mode_i (add_mode_i),
                .mask_bit_i (neg_mask_i[l]),
                .abs_en_i   (abs_en_i),
                .opnd_o     (prep_vec[l*FP_W +: FP_W])
            );
            fp32_lane_pick u_pick (
                .acc_op_i   (s1_accop[l*FP_W +: FP_W]),
                .opnd_i     (s1_opnd[l*FP_W +: FP_W]),
                .cmp_mode_i (s1_cmp),
                .res_o      (res_vec[l*FP_W +: FP_W]),
                .pick_acc_o (pick_vec[l])
            );

            // R6
            pick_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (s1_vld && (s1_cmp == PICK_MIN || s1_cmp == PICK_MAX)) |=>
                (pick_acc_o[l] ? (acc_o[l*FP_W +: FP_W] == $past(s1_accop[l*FP_W +: FP_W]))
                               : (acc_o[l*FP_W +: FP_W] == $past(s1_opnd[l*FP_W +: FP_W]))));
        end
    endgenerate

    // Stage 1: capture signed products, accumulator operand and compare mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld   <= 1'b0;
            s1_cmp   <= PICK_SUM;
            s1_accop <= '0;
            s1_opnd  <= '0;
        end else begin
            s1_vld <= accept;
            if (accept) begin
                s1_accop <= op_clear_i ? '0 : acc_q;
                s1_opnd  <= prep_vec;
                s1_cmp   <= cmp_mode_e'(cmp_mode_i);
            end
        end
    end

    // Stage 2: write the accumulator and flags when stage 1 holds an operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            pick_q    <= '0;
            res_vld_q <= 1'b0;
        end else begin
            res_vld_q <= s1_vld;
            if (s1_vld) begin
                acc_q  <= res_vec;
                pick_q <= pick_vec;
            end
        end
    end

    // Hazard pulse for a dropped request.
    always_ff @(posedge clk) begin
        if (!rst_n) hazard_q <= 1'b0;
        else        hazard_q <= op_valid_i && s1_vld && !op_clear_i;
    end

    assign acc_o       = acc_q;
    assign pick_acc_o  = pick_q;
    assign res_valid_o = res_vld_q;
    assign hazard_o    = hazard_q;

    // R8
    lat_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> ##2 res_valid_o);
    // R8
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_vld |=> $stable(acc_o));
    // R9
    hazard_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && s1_vld && !op_clear_i) |=> hazard_o);
    // R9
    hazard_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid_i && s1_vld && !op_clear_i) |=> !s1_vld);
    // R5
    sum_flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && (s1_cmp == PICK_SUM || s1_cmp == PICK_SUM_ALT)) |=> (pick_acc_o == '0));

endmodule

// File: tb/test_fp32_lane_accum.sv
`timescale 1ns/100ps
module test_fp32_lane_accum;

    localparam logic [31:0] ONE = 32'h3F800000, HALF = 32'h3F000000, TWO = 32'h40000000;
    localparam logic [31:0] THREE = 32'h40400000, FOUR = 32'h40800000, N1 = 32'hBF800000;
    localparam logic [31:0] N15 = 32'hBFC00000, N2 = 32'hC0000000, P25 = 32'h40200000;
    localparam logic [31:0] P35 = 32'h40600000, NH = 32'hBF000000, Z = 32'h0, NZ = 32'h80000000;

    function automatic logic [255:0] rep8(input logic [31:0] x);
        return {8{x}};
    endfunction
    function automatic logic [255:0] ln8(input logic [31:0] a0, a1, a2, a3, a4, a5, a6, a7);
        return {a7, a6, a5, a4, a3, a2, a1, a0};
    endfunction

    typedef struct packed {
        logic [3:0]   req;
        logic         clr;
        logic [1:0]   mode;
        logic [7:0]   mask;
        logic         absv;
        logic [1:0]   cmp;
        logic [255:0] prod;
        logic [255:0] exp_acc;
        logic [7:0]   exp_pick;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t TBL [NV] = '{
        '{4'd10, 1'b1, 2'd0, 8'h00, 1'b0, 2'd0, rep8(ONE), rep8(ONE), 8'h00},                       // R10 load
        '{4'd2,  1'b0, 2'd1, 8'h00, 1'b0, 2'd0, rep8(HALF), rep8(HALF), 8'h00},                     // R2 all sub
        '{4'd2,  1'b0, 2'd2, 8'h00, 1'b0, 2'd0, rep8(TWO), ln8(P25,N15,P25,N15,P25,N15,P25,N15), 8'h00}, // R2 pairs
        '{4'd3,  1'b0, 2'd3, 8'h0F, 1'b0, 2'd0, rep8(HALF), ln8(THREE,N2,THREE,N2,TWO,N1,TWO,N1), 8'h00}, // R3 R1
        '{4'd4,  1'b0, 2'd0, 8'h00, 1'b1, 2'd0, rep8(N1), ln8(FOUR,N1,FOUR,N1,THREE,Z,THREE,Z), 8'h00},  // R4
        '{4'd4,  1'b0, 2'd1, 8'h00, 1'b1, 2'd0, rep8(NH), ln8(P35,N15,P35,N15,P25,NH,P25,NH), 8'h00},    // R4
        '{4'd5,  1'b0, 2'd0, 8'h00, 1'b0, 2'd1, rep8(ONE), ln8(ONE,N15,ONE,N15,ONE,NH,ONE,NH), 8'hAA},   // R5 min
        '{4'd6,  1'b0, 2'd1, 8'h00, 1'b0, 2'd2, rep8(ONE), ln8(ONE,N1,ONE,N1,ONE,NH,ONE,NH), 8'hF5},     // R6 max
        '{4'd5,  1'b0, 2'd0, 8'h00, 1'b0, 2'd1, rep8(ONE), ln8(ONE,N1,ONE,N1,ONE,NH,ONE,NH), 8'hAA},     // R5 equal
        '{4'd6,  1'b0, 2'd0, 8'h00, 1'b0, 2'd2, rep8(ONE), rep8(ONE), 8'h55},                       // R6 equal
        '{4'd7,  1'b1, 2'd1, 8'h00, 1'b0, 2'd2, rep8(Z), rep8(Z), 8'hFF},                           // R7
        '{4'd3,  1'b1, 2'd0, 8'h81, 1'b0, 2'd0, rep8(TWO), ln8(N2,TWO,TWO,TWO,TWO,TWO,TWO,N2), 8'h00},   // R3
        '{4'd10, 1'b1, 2'd0, 8'h00, 1'b0, 2'd0, rep8(ONE), rep8(ONE), 8'h00},                       // R10
        '{4'd11, 1'b0, 2'd0, 8'h00, 1'b0, 2'd0, rep8(32'h33C00000), rep8(ONE), 8'h00},              // R11
        '{4'd11, 1'b0, 2'd1, 8'h00, 1'b0, 2'd0, rep8(32'h33000000), rep8(32'h3F7FFFFF), 8'h00},     // R11
        '{4'd12, 1'b0, 2'd0, 8'h00, 1'b0, 2'd0, rep8(32'h00400000), rep8(32'h3F7FFFFF), 8'h00},     // R12
        '{4'd12, 1'b1, 2'd0, 8'h00, 1'b0, 2'd0, rep8(32'h00000001), rep8(Z), 8'h00},                // R12
        '{4'd7,  1'b0, 2'd1, 8'h00, 1'b0, 2'd1, rep8(32'h00000001), rep8(NZ), 8'h00},               // R7
        '{4'd13, 1'b1, 2'd0, 8'h00, 1'b0, 2'd0, rep8(32'h7F7FFFFF), rep8(32'h7F7FFFFF), 8'h00},     // R13
        '{4'd13, 1'b0, 2'd0, 8'h00, 1'b0, 2'd0, rep8(32'h7F7FFFFF), rep8(32'h7F800000), 8'h00},     // R13
        '{4'd13, 1'b0, 2'd1, 8'h00, 1'b0, 2'd0, rep8(32'h7F800000), rep8(Z), 8'h00},                // R13
        '{4'd13, 1'b1, 2'd0, 8'h00, 1'b0, 2'd0, rep8(32'h7FC00000), rep8(32'h7F800000), 8'h00},     // R13
        '{4'd12, 1'b1, 2'd0, 8'h00, 1'b0, 2'd0, rep8(32'h00800000), rep8(32'h00800000), 8'h00},     // R12
        '{4'd12, 1'b0, 2'd1, 8'h00, 1'b0, 2'd0, rep8(32'h00C00000), rep8(NZ), 8'h00}                // R12
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         op_valid = 1'b0, op_clear = 1'b0, abs_en = 1'b0;
    logic [1:0]   add_mode = '0, cmp_mode = '0;
    logic [7:0]   neg_mask = '0;
    logic [255:0] prod = '0;
    logic [255:0] acc;
    logic [7:0]   pick;
    logic         res_valid, hazard;
    int           n_chk = 0, n_fail = 0;
    logic [255:0] prev_acc = '0;

    always #2.5 clk = ~clk;

    fp32_lane_accum i_fp32_lane_accum (
        .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid), .op_clear_i(op_clear),
        .add_mode_i(add_mode), .neg_mask_i(neg_mask), .abs_en_i(abs_en),
        .cmp_mode_i(cmp_mode), .prod_i(prod), .acc_o(acc), .pick_acc_o(pick),
        .res_valid_o(res_valid), .hazard_o(hazard)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic drive(input logic v, input logic c, input logic [1:0] m, input logic [7:0] k,
                         input logic a, input logic [1:0] cm, input logic [255:0] p);
        op_valid = v; op_clear = c; add_mode = m; neg_mask = k;
        abs_en = a; cmp_mode = cm; prod = p;
    endtask

    // One table operation: issue, idle one cycle, check the result (R8 timing too).
    task automatic run_vec(input vec_t v);
        string rq;
        rq = $sformatf("R%0d", v.req);
        @(negedge clk);
        drive(1'b1, v.clr, v.mode, v.mask, v.absv, v.cmp, v.prod);
        @(negedge clk);
        drive(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 2'd0, '0);
        // R8: nothing written one cycle after accept
        chk(!res_valid && acc == prev_acc, "R8", "early write", acc, prev_acc);
        @(negedge clk);
        chk(res_valid == 1'b1, "R8", "res_valid", {255'd0, res_valid}, 256'd1);
        chk(acc == v.exp_acc, rq, "acc", acc, v.exp_acc);
        chk(pick == v.exp_pick, rq, "pick", {248'd0, pick}, {248'd0, v.exp_pick});
        prev_acc = v.exp_acc;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        chk(1'b0, "R8", "watchdog expired", '0, '0);
        report();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R14 reset state
        chk(acc == '0, "R14", "acc", acc, '0);
        chk(pick == '0 && !res_valid && !hazard, "R14", "flags",
            {253'd0, |pick, res_valid, hazard}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(acc == '0 && !res_valid, "R14", "after release", acc, '0);

        for (int i = 0; i < NV; i++) run_vec(TBL[i]);

        // R9: dependent request one cycle after accept is dropped and flagged
        @(negedge clk);
        drive(1'b1, 1'b1, 2'd0, 8'h00, 1'b0, 2'd0, rep8(ONE));
        @(negedge clk);
        drive(1'b1, 1'b0, 2'd0, 8'h00, 1'b0, 2'd0, rep8(TWO));
        @(negedge clk);
        drive(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 2'd0, '0);
        chk(hazard == 1'b1, "R9", "hazard pulse", {255'd0, hazard}, 256'd1);
        chk(acc == rep8(ONE), "R9", "first result", acc, rep8(ONE));
        @(negedge clk);
        chk(hazard == 1'b0 && !res_valid, "R9", "pulse end / no write",
            {254'd0, hazard, res_valid}, '0);
        chk(acc == rep8(ONE), "R9", "dropped request ignored", acc, rep8(ONE));

        // R9 R10: clear requests back to back are both accepted
        drive(1'b1, 1'b1, 2'd0, 8'h00, 1'b0, 2'd0, rep8(TWO));
        @(negedge clk);
        drive(1'b1, 1'b1, 2'd0, 8'h00, 1'b0, 2'd0, rep8(THREE));
        @(negedge clk);
        drive(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 2'd0, '0);
        chk(acc == rep8(TWO) && !hazard, "R9", "first clear op", acc, rep8(TWO));
        @(negedge clk);
        chk(acc == rep8(THREE) && res_valid, "R10", "second clear op", acc, rep8(THREE));

        // R14: reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk(acc == '0 && pick == '0, "R14", "re-reset", acc, '0);
        rst_n = 1'b1;
        @(negedge clk);

        report();
        $finish;
    end

endmodule